// File: doc/BRIEF.md
# Word-Granular Self-Invalidating L1 State Array

This block keeps the coherence metadata of a private L1 data cache. The cache has no sharer directory and receives no invalidations from other caches. Instead, software marks the end of each parallel phase, and the cache drops its own stale copies at that point. For every word of every line the array holds four things: a two-bit state (Invalid, Valid or Registered), a touched flag, a region tag and a flag that shows a registration request is outstanding. It classifies each local access as a hit, a miss, a registration request or a stall. It merges partial-line fills word by word and applies registration grants.

An end-of-phase command names one region. The array then walks its sets one per cycle. In each set it invalidates the Valid words that carry that region and were not accessed during the phase. Registered words are always kept, because this cache holds their current value. The touched flags of the whole array are cleared in the last cycle of the walk, so the next phase starts clean. Data storage, tag comparison and the network lie outside the block; the requests it produces go toward the shared level.

Top module: `l1si_state_array`

## Requirements
- R1: After reset every word is Invalid, touched and pending flags are clear, `busy` is low, and a read of any word misses.
- R2: A read while `busy` is low classifies the addressed word. An Invalid word (code 00) raises `miss_req_valid` in the same cycle, with `miss_req_index`/`miss_req_word` equal to the access. A Valid (01) or Registered (10) word raises `acc_hit` and no request. At most one of hit, stall, miss request and registration request is high in any cycle.
- R3: A fill sets word w of `fill_index` Valid when bit w of `fill_mask` is 1 and the word is Invalid. Words whose mask bit is 0, and words that are already Valid or Registered, are left unchanged.
- R4: A write to a word that is not Registered and has no pending registration raises `reg_req_valid` in the same cycle, with `reg_req_index`/`reg_req_word` equal to the access, and no hit. After a grant for that word, writes to it hit with no request.
- R5: A write to a word whose registration is still outstanding raises `acc_stall`, issues no request and changes no metadata.
- R6: `phase_end_valid` while `busy` is low makes `busy` high from the next cycle for exactly SETS cycles, one set per cycle. Every Valid, untouched word whose tag equals `phase_end_region` becomes Invalid.
- R7: A word that had an accepted access since the last completed sweep is not invalidated by the sweep.
- R8: A Registered word is never invalidated by a sweep, whatever its tag or touched flag.
- R9: A sweep leaves unchanged every word whose tag differs from the commanded region.
- R10: Touched flags are cleared in the final sweep cycle. A Valid word that is not accessed during the following phase is invalidated by the next sweep for its region.
- R11: While `busy` is high, every access gets `acc_stall` with no hit, no request and no effect on metadata, and `phase_end_valid` is ignored.
- R12: A word's tag is the region of its most recent accepted access, misses included. Stalled accesses leave the tag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Local access present |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_index | input | clog2(SETS) | Set of the access |
| acc_word | input | clog2(WORDS) | Word within the line |
| acc_region | input | RGN_W | Region of the access |
| acc_hit | output | 1 | Access satisfied locally |
| acc_stall | output | 1 | Access refused; retry later |
| miss_req_valid | output | 1 | Read miss request toward the shared level |
| miss_req_index | output | clog2(SETS) | Set of the miss |
| miss_req_word | output | clog2(WORDS) | Word of the miss |
| reg_req_valid | output | 1 | Write ownership request |
| reg_req_index | output | clog2(SETS) | Set of the ownership request |
| reg_req_word | output | clog2(WORDS) | Word of the ownership request |
| fill_valid | input | 1 | Fill response present |
| fill_index | input | clog2(SETS) | Set being filled |
| fill_mask | input | WORDS | Words carried by the fill |
| grant_valid | input | 1 | Ownership grant present |
| grant_index | input | clog2(SETS) | Set of the grant |
| grant_word | input | clog2(WORDS) | Word of the grant |
| phase_end_valid | input | 1 | End-of-phase command |
| phase_end_region | input | RGN_W | Region to self-invalidate |
| busy | output | 1 | Sweep in progress |

## Verification
The hardest case to reach is a Valid word that carries the commanded region but was not accessed during the phase. Every read used to observe a word also marks it touched, so a word can only become a sweep victim after one sweep has cleared its flag and a whole phase has passed without a read of it. The stimulus builds this with sweeps placed back to back, and looks at the word only after the second sweep. A long pseudo-random mix of accesses, fills, grants and sweeps is then compared against a word-level model in the bench. The same mix also produces writes that hit an outstanding registration and accesses that arrive during a sweep.

// File: rtl/l1si_pkg.sv
package l1si_pkg;

  typedef enum logic [1:0] {
    WS_INV = 2'b00,
    WS_VAL = 2'b01,
    WS_REG = 2'b10
  } wstate_e;

  localparam int RGN_MAX = 8;
  typedef logic [RGN_MAX-1:0] rgn_wide_t;

  typedef struct packed {
    logic hit;
    logic stall;
    logic miss;
    logic regq;
  } acc_res_t;

  // True when a sweep for region cmd must drop this word.
  function automatic logic sweep_drops(wstate_e st, logic tch, rgn_wide_t tag, rgn_wide_t cmd);
    return (st == WS_VAL) && !tch && (tag == cmd);
  endfunction

  // Fill merge: only an Invalid word takes the arriving value.
  function automatic wstate_e fill_merge(wstate_e st);
    return (st == WS_INV) ? WS_VAL : st;
  endfunction

  // Outcome of a local access on a word with state st and pending flag pend.
  function automatic acc_res_t classify(wstate_e st, logic pend, logic wr);
    acc_res_t r;
    r = '0;
    if (!wr) begin
      if (st == WS_INV) r.miss = 1'b1;
      else              r.hit  = 1'b1;
    end else if (st == WS_REG) begin
      r.hit = 1'b1;
    end else if (pend) begin
      r.stall = 1'b1;
    end else begin
      r.regq = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/l1si_word_cell.sv
module l1si_word_cell
  import l1si_pkg::*;
#(
  parameter int RGN_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic             acc_wr,
  input  logic [RGN_W-1:0] acc_rgn,
  input  logic             fill_en,
  input  logic             grant_en,
  input  logic             sweep_en,
  input  logic [RGN_W-1:0] sweep_rgn,
  input  logic             clr_tch,
  output wstate_e          st_o,
  output logic             pend_o
);

  wstate_e          st_q, st_d;
  logic             tch_q, tch_d;
  logic [RGN_W-1:0] rgn_q, rgn_d;
  logic             pend_q, pend_d;
  logic             drop_now;

  assign drop_now = sweep_en &&
                    sweep_drops(st_q, tch_q, rgn_wide_t'(rgn_q), rgn_wide_t'(sweep_rgn));

  always_comb begin
    st_d = st_q;
    if (drop_now) st_d = WS_INV;
    if (fill_en)  st_d = fill_merge(st_d);
    if (grant_en) st_d = WS_REG;

    tch_d = clr_tch ? 1'b0 : tch_q;
    if (acc_en) tch_d = 1'b1;

    rgn_d = acc_en ? acc_rgn : rgn_q;

    pend_d = pend_q;
    if (acc_en && acc_wr && (st_q != WS_REG)) pend_d = 1'b1;
    if (grant_en) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WS_INV;
      tch_q  <= 1'b0;
      rgn_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      tch_q  <= tch_d;
      rgn_q  <= rgn_d;
      pend_q <= pend_d;
    end
  end

  assign st_o   = st_q;
  assign pend_o = pend_q;

endmodule

// File: rtl/l1si_sweep_ctrl.sv
module l1si_sweep_ctrl #(
  parameter int SETS  = 8,
  parameter int RGN_W = 1,
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic [RGN_W-1:0] start_rgn,
  output logic             busy,
  output logic [IDX_W-1:0] ptr,
  output logic [RGN_W-1:0] rgn,
  output logic             last
);

  assign last = busy && (ptr == IDX_W'(SETS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ptr  <= '0;
      rgn  <= '0;
    end else if (!busy) begin
      if (start_req) begin
        busy <= 1'b1;
        ptr  <= '0;
        rgn  <= start_rgn;
      end
    end else begin
      if (last) busy <= 1'b0;
      ptr <= last ? '0 : ptr + IDX_W'(1);
    end
  end

endmodule

// File: rtl/l1si_access_front.sv
module l1si_access_front
  import l1si_pkg::*;
#(
  parameter int SETS  = 8,
  parameter int WORDS = 4,
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WRD_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [IDX_W-1:0] acc_index,
  input  logic [WRD_W-1:0] acc_word,
  input  logic             busy,
  input  wstate_e          sel_st,
  input  logic             sel_pend,
  output logic             acc_hit,
  output logic             acc_stall,
  output logic             miss_req_valid,
  output logic [IDX_W-1:0] miss_req_index,
  output logic [WRD_W-1:0] miss_req_word,
  output logic             reg_req_valid,
  output logic [IDX_W-1:0] reg_req_index,
  output logic [WRD_W-1:0] reg_req_word,
  output logic             acc_take
);

  acc_res_t res;

  always_comb begin
    res = classify(sel_st, sel_pend, acc_write);
    if (!acc_valid) begin
      res = '0;
    end else if (busy) begin
      res       = '0;
      res.stall = 1'b1;
    end
  end

  assign acc_hit        = res.hit;
  assign acc_stall      = res.stall;
  assign miss_req_valid = res.miss;
  assign reg_req_valid  = res.regq;
  assign miss_req_index = acc_index;
  assign miss_req_word  = acc_word;
  assign reg_req_index  = acc_index;
  assign reg_req_word   = acc_word;
  assign acc_take       = acc_valid && !res.stall;

endmodule

// File: rtl/l1si_state_array.sv
module l1si_state_array
  import l1si_pkg::*;
#(
  parameter int SETS  = 8,
  parameter int WORDS = 4,
  parameter int RGN_W = 1,
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WRD_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [IDX_W-1:0] acc_index,
  input  logic [WRD_W-1:0] acc_word,
  input  logic [RGN_W-1:0] acc_region,
  output logic             acc_hit,
  output logic             acc_stall,
  output logic             miss_req_valid,
  output logic [IDX_W-1:0] miss_req_index,
  output logic [WRD_W-1:0] miss_req_word,
  output logic             reg_req_valid,
  output logic [IDX_W-1:0] reg_req_index,
  output logic [WRD_W-1:0] reg_req_word,
  input  logic             fill_valid,
  input  logic [IDX_W-1:0] fill_index,
  input  logic [WORDS-1:0] fill_mask,
  input  logic             grant_valid,
  input  logic [IDX_W-1:0] grant_index,
  input  logic [WRD_W-1:0] grant_word,
  input  logic             phase_end_valid,
  input  logic [RGN_W-1:0] phase_end_region,
  output logic             busy
);

  localparam int CELLS  = SETS * WORDS;
  localparam int CELL_W = (CELLS > 1) ? $clog2(CELLS) : 1;

  // Named internal events, also seen by the bound checker.
  logic             acc_take;
  logic             sweep_last;
  logic [IDX_W-1:0] sweep_ptr;
  logic [RGN_W-1:0] sweep_rgn;
  logic [CELL_W-1:0] sel_cell;

  wstate_e st_arr   [CELLS];
  logic    pend_arr [CELLS];

  assign sel_cell = CELL_W'(acc_index) * CELL_W'(WORDS) + CELL_W'(acc_word);

  l1si_sweep_ctrl #(.SETS(SETS), .RGN_W(RGN_W)) u_sweep (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (phase_end_valid),
    .start_rgn (phase_end_region),
    .busy      (busy),
    .ptr       (sweep_ptr),
    .rgn       (sweep_rgn),
    .last      (sweep_last)
  );

  l1si_access_front #(.SETS(SETS), .WORDS(WORDS)) u_front (
    .acc_valid      (acc_valid),
    .acc_write      (acc_write),
    .acc_index      (acc_index),
    .acc_word       (acc_word),
    .busy           (busy),
    .sel_st         (st_arr[sel_cell]),
    .sel_pend       (pend_arr[sel_cell]),
    .acc_hit        (acc_hit),
    .acc_stall      (acc_stall),
    .miss_req_valid (miss_req_valid),
    .miss_req_index (miss_req_index),
    .miss_req_word  (miss_req_word),
    .reg_req_valid  (reg_req_valid),
    .reg_req_index  (reg_req_index),
    .reg_req_word   (reg_req_word),
    .acc_take       (acc_take)
  );

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic set_acc, set_fill, set_grant, set_sweep;
    assign set_acc   = acc_take && (acc_index == IDX_W'(s));
    assign set_fill  = fill_valid && (fill_index == IDX_W'(s));
    assign set_grant = grant_valid && (grant_index == IDX_W'(s));
    assign set_sweep = busy && (sweep_ptr == IDX_W'(s));

    for (genvar w = 0; w < WORDS; w++) begin : g_word
      l1si_word_cell #(.RGN_W(RGN_W)) u_cell (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (set_acc && (acc_word == WRD_W'(w))),
        .acc_wr    (acc_write),
        .acc_rgn   (acc_region),
        .fill_en   (set_fill && fill_mask[w]),
        .grant_en  (set_grant && (grant_word == WRD_W'(w))),
        .sweep_en  (set_sweep),
        .sweep_rgn (sweep_rgn),
        .clr_tch   (sweep_last),
        .st_o      (st_arr[s*WORDS + w]),
        .pend_o    (pend_arr[s*WORDS + w])
      );
    end
  end

endmodule

// File: rtl/l1si_state_array_chk.sv
module l1si_state_array_chk #(
  parameter int SETS = 8
) (
  input logic clk,
  input logic rst_n,
  input logic acc_valid,
  input logic acc_write,
  input logic acc_hit,
  input logic acc_stall,
  input logic miss_req_valid,
  input logic reg_req_valid,
  input logic phase_end_valid,
  input logic busy,
  input logic sweep_last
);

  localparam int CW = $clog2(SETS) + 1;
  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     busy_cnt <= '0;
    else if (!busy) busy_cnt <= '0;
    else            busy_cnt <= busy_cnt + CW'(1);
  end

  assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({acc_hit, acc_stall, miss_req_valid, reg_req_valid}));

  assert_miss_from_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    miss_req_valid |-> (acc_valid && !acc_write));

  assert_regreq_from_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req_valid |-> (acc_valid && acc_write));

  assert_stall_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stall && !busy) |-> acc_write);

  assert_sweep_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_end_valid && !busy) |=> busy);

  assert_sweep_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (busy_cnt < CW'(SETS - 1))) |=> busy);

  assert_sweep_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (busy_cnt == CW'(SETS - 1))) |-> sweep_last);

  assert_last_drops_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_last |=> !busy);

  assert_quiet_in_sweep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!acc_hit && !miss_req_valid && !reg_req_valid));

  assert_stall_in_sweep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && acc_valid) |-> acc_stall);

endmodule

bind l1si_state_array l1si_state_array_chk #(.SETS(SETS)) u_chk (.*);

// File: tb/sim_l1si_state_array.sv
`timescale 1ns/1ps
module sim_l1si_state_array;

  localparam int SETS  = 8;
  localparam int WORDS = 4;
  localparam int RGN_W = 1;
  localparam int IDX_W = $clog2(SETS);
  localparam int WRD_W = $clog2(WORDS);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             acc_valid = 1'b0, acc_write = 1'b0;
  logic [IDX_W-1:0] acc_index = '0;
  logic [WRD_W-1:0] acc_word = '0;
  logic [RGN_W-1:0] acc_region = '0;
  logic             acc_hit, acc_stall, miss_req_valid, reg_req_valid, busy;
  logic [IDX_W-1:0] miss_req_index, reg_req_index;
  logic [WRD_W-1:0] miss_req_word, reg_req_word;
  logic             fill_valid = 1'b0;
  logic [IDX_W-1:0] fill_index = '0;
  logic [WORDS-1:0] fill_mask = '0;
  logic             grant_valid = 1'b0;
  logic [IDX_W-1:0] grant_index = '0;
  logic [WRD_W-1:0] grant_word = '0;
  logic             phase_end_valid = 1'b0;
  logic [RGN_W-1:0] phase_end_region = '0;

  always #2.5 clk = ~clk;

  l1si_state_array #(.SETS(SETS), .WORDS(WORDS), .RGN_W(RGN_W)) u0 (.*);

  // Word-level model: 0 Invalid, 1 Valid, 2 Registered.
  int m_st [SETS][WORDS];
  bit m_t  [SETS][WORDS];
  bit m_p  [SETS][WORDS];
  int m_r  [SETS][WORDS];

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    acc_valid = 1'b0; fill_valid = 1'b0; grant_valid = 1'b0; phase_end_valid = 1'b0;
  endtask

  task automatic do_acc(int s, int w, bit wr, int rg, string req);
    int e_hit, e_stall, e_miss, e_reg;
    string lab;
    @(negedge clk);
    idle();
    acc_valid = 1'b1; acc_write = wr; acc_index = IDX_W'(s);
    acc_word = WRD_W'(w); acc_region = RGN_W'(rg);
    #1;
    e_hit = 0; e_stall = 0; e_miss = 0; e_reg = 0;
    if (!wr) begin
      if (m_st[s][w] == 0) e_miss = 1; else e_hit = 1;
    end else if (m_st[s][w] == 2) e_hit = 1;
    else if (m_p[s][w]) e_stall = 1;
    else e_reg = 1;
    lab = req;
    if (lab == "") lab = e_miss ? "R2" : e_reg ? "R4" : e_stall ? "R5" : "R2";
    chk(lab, "hit/stall/miss/reg", {acc_hit, acc_stall, miss_req_valid, reg_req_valid},
        {e_hit[0], e_stall[0], e_miss[0], e_reg[0]});
    if (e_miss) chk(lab, "miss set*words+word", int'(miss_req_index) * WORDS + int'(miss_req_word), s * WORDS + w);
    if (e_reg)  chk(lab, "reg set*words+word", int'(reg_req_index) * WORDS + int'(reg_req_word), s * WORDS + w);
    if (!e_stall) begin
      m_t[s][w] = 1'b1;
      m_r[s][w] = rg;
      if (e_reg) m_p[s][w] = 1'b1;
    end
    @(posedge clk); #1;
    idle();
  endtask

  task automatic do_fill(int s, int mask);
    @(negedge clk);
    idle();
    fill_valid = 1'b1; fill_index = IDX_W'(s); fill_mask = WORDS'(mask);
    for (int w = 0; w < WORDS; w++)
      if (mask[w] && m_st[s][w] == 0) m_st[s][w] = 1;
    @(posedge clk); #1;
    idle();
  endtask

  task automatic do_grant(int s, int w);
    @(negedge clk);
    idle();
    grant_valid = 1'b1; grant_index = IDX_W'(s); grant_word = WRD_W'(w);
    m_st[s][w] = 2; m_p[s][w] = 1'b0;
    @(posedge clk); #1;
    idle();
  endtask

  // Sweep for region rg; with poke set, an access and a second command
  // arrive during the sweep and must be refused and ignored.
  task automatic do_sweep(int rg, bit poke);
    int n;
    @(negedge clk);
    idle();
    chk("R6", "busy before command", busy, 0);
    phase_end_valid = 1'b1; phase_end_region = RGN_W'(rg);
    @(posedge clk); #1;
    idle();
    chk("R6", "busy after command", busy, 1);
    n = 0;
    while (busy && n < SETS + 4) begin
      @(negedge clk);
      if (poke && n == 1) begin
        acc_valid = 1'b1; acc_write = 1'b1; acc_index = '0; acc_word = '0;
        acc_region = RGN_W'(rg + 1);
        phase_end_valid = 1'b1; phase_end_region = RGN_W'(rg + 1);
        #1;
        chk("R11", "outputs during sweep", {acc_hit, acc_stall, miss_req_valid, reg_req_valid}, 4'b0100);
      end
      @(posedge clk); #1;
      idle();
      n++;
    end
    chk("R6", "sweep length", n, SETS);
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WORDS; w++) begin
        if (m_st[s][w] == 1 && !m_t[s][w] && m_r[s][w] == rg) m_st[s][w] = 0;
        m_t[s][w] = 1'b0;
      end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL all watchdog: got 1 expected 0");
    finish_run();
  end

  initial begin
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WORDS; w++) begin
        m_st[s][w] = 0; m_t[s][w] = 0; m_p[s][w] = 0; m_r[s][w] = 0;
      end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1 chk("R1", "busy after reset", busy, 0);

    // R1: every word misses after reset.
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WORDS; w++) do_acc(s, w, 1'b0, 0, "R1");

    // R3: partial fill merges only masked words.
    do_fill(0, 4'b0101);
    do_acc(0, 0, 1'b0, 0, "R3");
    do_acc(0, 1, 1'b0, 0, "R3");
    do_acc(0, 2, 1'b0, 0, "R3");

    // R4 / R5: registration, stall while pending, then grant.
    do_acc(1, 2, 1'b1, 0, "R4");
    do_acc(1, 2, 1'b1, 1, "R5");
    do_acc(1, 2, 1'b0, 0, "R5");
    do_grant(1, 2);
    do_acc(1, 2, 1'b1, 0, "R4");
    do_fill(1, 4'b1111);
    do_acc(1, 2, 1'b1, 0, "R3");

    // R7 / R9 / R10: touched survive, other region kept, untouched dropped.
    do_acc(2, 0, 1'b0, 1, "R12");
    do_acc(2, 1, 1'b0, 0, "R12");
    do_acc(2, 2, 1'b0, 1, "R12");
    do_fill(2, 4'b0111);
    do_sweep(1, 1'b0);
    do_acc(2, 2, 1'b0, 1, "R7");
    do_sweep(1, 1'b0);
    do_acc(2, 0, 1'b0, 1, "R10");
    do_acc(2, 1, 1'b0, 0, "R9");
    do_acc(2, 2, 1'b0, 1, "R7");

    // R8 / R11: Registered word survives; refused access leaves no trace.
    do_sweep(0, 1'b1);
    do_acc(1, 2, 1'b1, 0, "R8");
    do_acc(0, 0, 1'b1, 0, "R11");

    // R12: tag follows the latest access.
    do_acc(3, 0, 1'b0, 1, "R12");
    do_fill(3, 4'b0001);
    do_acc(3, 0, 1'b0, 0, "R12");
    do_sweep(0, 1'b0);
    do_sweep(1, 1'b0);
    do_acc(3, 0, 1'b0, 0, "R12");

    // Pseudo-random mix against the model.
    for (int i = 0; i < 2500; i++) begin
      int r, s, w;
      r = int'($urandom % 100);
      s = int'($urandom % SETS);
      w = int'($urandom % WORDS);
      if (r < 55)      do_acc(s, w, 1'($urandom % 2), int'($urandom % 2), "");
      else if (r < 75) do_fill(s, int'($urandom % 16));
      else if (r < 93) begin
        if (m_p[s][w]) do_grant(s, w);
        else do_acc(s, w, 1'b0, int'($urandom % 2), "");
      end
      else do_sweep(int'($urandom % 2), r == 99);
    end

    finish_run();
  end

endmodule